// File: doc/BRIEF.md
# Priority-Resolved Shift and Rotate Register

This block is a clocked data register, one byte wide by default. Each rising clock edge applies at most one of five moves: a logical shift toward the low end, a rotate toward the low end, a logical shift toward the high end, a rotate toward the high end, or a parallel load from the data input. The five request inputs are meant to be used one at a time. When a user asserts several in the same cycle, a fixed priority picks exactly one of them, so the next value is always defined.

The priority rules are as follows:
- Moves toward the low end win over moves toward the high end.
- Within one direction, a shift wins over a rotate.
- Any move wins over a load.
- With no request asserted, the register keeps its value.

Shifts fill the vacated end with zero. Rotates carry the bit that leaves one end back into the other end.

Top module: `prio_shift_reg`

## Requirements
- R1: An asynchronous active-low reset clears the output to all zeros, and holds it there for as long as reset is low, whatever the requests are.
- R2: When the shift-down request is high, the next output is the current output moved one place toward bit 0, with 0 entering the top bit. This holds whatever else is asserted.
- R3: When shift-down is low and rotate-down is high, the next output is the current output moved one place toward bit 0, with the old bit 0 entering the top bit. This holds whatever else is asserted.
- R4: When both downward requests are low and shift-up is high, the next output is the current output moved one place toward the top bit, with 0 entering bit 0. This holds whatever else is asserted, including the undefined pairing of shift-up with either downward request.
- R5: When rotate-up is the only move request, the next output is the current output moved one place toward the top bit, with the old top bit entering bit 0. This happens even if load is also high.
- R6: When load is the only asserted request, the next output equals the data input.
- R7: When no request is asserted, the output keeps its value, and the data input has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_shr | input | 1 | Logical shift toward bit 0 (highest priority) |
| req_rotr | input | 1 | Rotate toward bit 0 |
| req_shl | input | 1 | Logical shift toward the top bit |
| req_rotl | input | 1 | Rotate toward the top bit |
| req_load | input | 1 | Parallel load (lowest priority) |
| din | input | WIDTH | Parallel load data |
| dout | output | WIDTH | Register contents |

## Verification
Any two requests, and in fact all five, can be asserted in the same cycle. The case that matters most is a downward move paired with an upward move or with a load. The bench walks all 32 combinations of the request inputs, many times over, each time with fresh random load data and a register value that has already been disturbed by earlier steps. On every clock it compares the output with a behavioural model that resolves the requests through the stated priority. A reset pulse applied while every request is high checks that reset overrides all of them.

// File: rtl/prio_shift_pkg.sv
package prio_shift_pkg;

  typedef enum logic [2:0] {
    OP_HOLD = 3'd0,
    OP_SHR  = 3'd1,
    OP_ROTR = 3'd2,
    OP_SHL  = 3'd3,
    OP_ROTL = 3'd4,
    OP_LOAD = 3'd5
  } shift_op_e;

  typedef struct packed {
    logic go_down;   // move toward bit 0
    logic go_up;     // move toward the top bit
    logic wrap;      // rotate: recirculate the leaving bit
    logic take_din;  // parallel load
    logic en;        // any update this cycle
  } shift_ctl_t;

endpackage

// File: rtl/prio_shift_decode.sv
module prio_shift_decode
  import prio_shift_pkg::*;
(
  input  logic       req_shr,
  input  logic       req_rotr,
  input  logic       req_shl,
  input  logic       req_rotl,
  input  logic       req_load,
  output shift_op_e  op,
  output shift_ctl_t ctl
);

  // fixed priority: down before up, shift before rotate, move before load
  always_comb begin
    if (req_shr)       op = OP_SHR;
    else if (req_rotr) op = OP_ROTR;
    else if (req_shl)  op = OP_SHL;
    else if (req_rotl) op = OP_ROTL;
    else if (req_load) op = OP_LOAD;
    else               op = OP_HOLD;
  end

  always_comb begin
    ctl          = '0;
    ctl.go_down  = (op == OP_SHR)  || (op == OP_ROTR);
    ctl.go_up    = (op == OP_SHL)  || (op == OP_ROTL);
    ctl.wrap     = (op == OP_ROTR) || (op == OP_ROTL);
    ctl.take_din = (op == OP_LOAD);
    ctl.en       = (op != OP_HOLD);
  end

  always_comb begin
    assert ($onehot0({ctl.go_down, ctl.go_up, ctl.take_din}))
      else $error("AST_ONE_SOURCE: more than one data source selected"); // R2
    assert (!(ctl.wrap && !(ctl.go_down || ctl.go_up)))
      else $error("AST_WRAP_NEEDS_MOVE: wrap without a move"); // R3
  end

endmodule

// File: rtl/prio_shift_datapath.sv
module prio_shift_datapath
  import prio_shift_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  shift_ctl_t       ctl,
  input  logic [WIDTH-1:0] cur,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] nxt
);

  localparam int TOP = WIDTH - 1;

  logic fill_top;   // bit entering the top position on a downward move
  logic fill_bot;   // bit entering bit 0 on an upward move

  assign fill_top = ctl.wrap & cur[0];
  assign fill_bot = ctl.wrap & cur[TOP];

  // one mux per bit, fed by its two neighbours
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic from_above;
    logic from_below;

    if (i == TOP) begin : g_top
      assign from_above = fill_top;
    end else begin : g_mid_a
      assign from_above = cur[i+1];
    end

    if (i == 0) begin : g_bot
      assign from_below = fill_bot;
    end else begin : g_mid_b
      assign from_below = cur[i-1];
    end

    always_comb begin
      if (ctl.go_down)       nxt[i] = from_above;
      else if (ctl.go_up)    nxt[i] = from_below;
      else if (ctl.take_din) nxt[i] = din[i];
      else                   nxt[i] = cur[i];
    end
  end

endmodule

// File: rtl/prio_shift_store.sv
module prio_shift_store #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [WIDTH-1:0] nxt,
  output logic [WIDTH-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (en) q <= nxt;
  end

endmodule

// File: rtl/prio_shift_reg.sv
module prio_shift_reg
  import prio_shift_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_shr,
  input  logic             req_rotr,
  input  logic             req_shl,
  input  logic             req_rotl,
  input  logic             req_load,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  localparam int TOP = WIDTH - 1;

  shift_op_e        op;
  shift_ctl_t       ctl;
  logic [WIDTH-1:0] nxt;

  prio_shift_decode u_decode (
    .req_shr  (req_shr),
    .req_rotr (req_rotr),
    .req_shl  (req_shl),
    .req_rotl (req_rotl),
    .req_load (req_load),
    .op       (op),
    .ctl      (ctl)
  );

  prio_shift_datapath #(.WIDTH(WIDTH)) u_path (
    .ctl (ctl),
    .cur (dout),
    .din (din),
    .nxt (nxt)
  );

  prio_shift_store #(.WIDTH(WIDTH)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (ctl.en),
    .nxt   (nxt),
    .q     (dout)
  );

  // armed after one full clock out of reset, so $past never reaches into reset
  logic armed_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= 1'b1;
  end

  AST_RESET_CLEARS: assert property (@(posedge clk)
    !rst_n |-> dout == '0); // R1

  AST_SHR_WINS: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
    $past(req_shr) |-> dout == {1'b0, $past(dout[TOP:1])}); // R2

  AST_ROTR_NEXT: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
    ($past(!req_shr) && $past(req_rotr)) |-> dout == {$past(dout[0]), $past(dout[TOP:1])}); // R3

  AST_SHL_NEXT: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
    ($past(!req_shr) && $past(!req_rotr) && $past(req_shl))
      |-> dout == {$past(dout[TOP-1:0]), 1'b0}); // R4

  AST_ROTL_NEXT: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
    ($past({req_shr, req_rotr, req_shl}) == 3'b000 && $past(req_rotl))
      |-> dout == {$past(dout[TOP-1:0]), $past(dout[TOP])}); // R5

  AST_LOAD_SOLE: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
    ($past({req_shr, req_rotr, req_shl, req_rotl, req_load}) == 5'b00001)
      |-> dout == $past(din)); // R6

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
    ($past({req_shr, req_rotr, req_shl, req_rotl, req_load}) == 5'b00000)
      |-> $stable(dout)); // R7

endmodule

// File: tb/tb_prio_shift_reg.sv
module tb_prio_shift_reg;

  localparam int W = 8;
  localparam time CLK_PERIOD = 10;

  logic         clk;
  logic         rst_n;
  logic         req_shr, req_rotr, req_shl, req_rotl, req_load;
  logic [W-1:0] din;
  logic [W-1:0] dout;

  int checks;
  int errors;
  bit finished;

  prio_shift_reg #(.WIDTH(W)) dut (
    .clk(clk), .rst_n(rst_n),
    .req_shr(req_shr), .req_rotr(req_rotr), .req_shl(req_shl),
    .req_rotl(req_rotl), .req_load(req_load),
    .din(din), .dout(dout)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // reference model: behavioural, integer arithmetic
  function automatic logic [W-1:0] model(input logic [4:0] r, input logic [W-1:0] cur,
                                         input logic [W-1:0] d);
    int v;
    v = int'(cur);
    if (r[4])      return W'(v / 2);                                  // shr
    else if (r[3]) return W'(v / 2 + (v % 2) * (1 << (W-1)));        // rotr
    else if (r[2]) return W'((v * 2) % (1 << W));                    // shl
    else if (r[1]) return W'((v * 2) % (1 << W) + v / (1 << (W-1))); // rotl
    else if (r[0]) return d;
    else           return cur;
  endfunction

  function automatic string req_tag(input logic [4:0] r);
    if (r[4])      return "R2";
    else if (r[3]) return "R3";
    else if (r[2]) return "R4";
    else if (r[1]) return "R5";
    else if (r[0]) return "R6";
    else           return "R7";
  endfunction

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [4:0] r, input logic [W-1:0] d);
    {req_shr, req_rotr, req_shl, req_rotl, req_load} = r;
    din = d;
  endtask

  logic [W-1:0] exp_q;

  initial begin
    checks = 0; errors = 0; finished = 0;
    rst_n = 1'b1;
    drive(5'b11111, 8'hA5);
    #1 rst_n = 1'b0;
    #1 check("R1", dout, '0);
    @(posedge clk); @(negedge clk);
    check("R1", dout, '0);
    rst_n = 1'b1;
    exp_q = '0;

    // seed a non-zero value: load sole
    drive(5'b00001, 8'h96);
    exp_q = model(5'b00001, exp_q, 8'h96);
    @(negedge clk);
    check("R6", dout, exp_q);

    // exhaustive request combinations, repeated with random data
    for (int rep = 0; rep < 24; rep++) begin
      for (int c = 0; c < 32; c++) begin
        logic [W-1:0] d;
        logic [4:0]   r;
        r = 5'(c);
        d = W'($urandom);
        // reload occasionally so the value does not drain to zero
        if (dout == '0 || dout == '1) begin
          drive(5'b00001, d);
          exp_q = model(5'b00001, exp_q, d);
          @(negedge clk);
          check("R6", dout, exp_q);
          d = W'($urandom);
        end
        drive(r, d);
        exp_q = model(r, exp_q, d);
        @(negedge clk);
        check(req_tag(r), dout, exp_q);
      end
    end

    // idle with changing data: nothing moves
    for (int k = 0; k < 4; k++) begin
      drive(5'b00000, W'($urandom));
      @(negedge clk);
      check("R7", dout, exp_q);
    end

    // reset mid-run with every request high
    drive(5'b11111, 8'hFF);
    rst_n = 1'b0;
    #1 check("R1", dout, '0);
    @(posedge clk); @(negedge clk);
    check("R1", dout, '0);
    drive(5'b00000, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", dout, '0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule